// File: doc/BRIEF.md
# User Sideband Stripping Adapter

This adapter connects an AXI4 manager whose address channels carry a user sideband to a subordinate port that has no user signals at all. Each accepted read or write address request has its user value stored in a small first-in first-out queue selected by the transaction ID. The request then goes downstream without that field. Read and write requests use separate sets of queues.

When a write response, or the final beat of a read burst, comes back for some ID, the adapter takes the oldest stored value for that ID. It attaches that value to the response sent to the manager and then removes it from the queue. Every beat of a read burst shows the same stored value, but only the beat with the last flag set consumes it. Within one ID, responses are expected in request order, as AXI requires.

An optional parameter limits how many transactions may be outstanding per ID. When it is left at zero, the queues take their largest built-in depth. A request whose ID queue is full is held off by keeping its ready signal low. Requests for other IDs can still pass.

Top module: `usr_strip_top`

## Requirements
- R1: An accepted read address request appears downstream in the same cycle with unchanged ID and address. Downstream valid is upstream valid gated by the ID queue not being full, and upstream ready is downstream ready gated the same way.
- R2: Write address requests follow the same forwarding rule as R1, using the write-side queues.
- R3: A read beat returned to the manager carries the user value of the oldest outstanding read request with that RID. All beats of a burst show that value. Only the beat with the last flag set consumes it.
- R4: A write response carries the user value of the oldest outstanding write request with that BID, and consumes it on the response handshake.
- R5: Several outstanding requests on one ID get their user values back in request order.
- R6: The per-ID cap is MAX_FLIGHT, or MAX_DEPTH (default 4) when MAX_FLIGHT is 0. A request for an ID that already has that many outstanding has ready low and is not forwarded. A request for a different ID is accepted in the same conditions.
- R7: Read and write queues are independent, so a read and a write on the same ID each get back their own user value.
- R8: Write data valid, ready, data and last pass straight through in both directions.
- R9: After reset every queue is empty, and address ready follows downstream ready on both channels.
- R10: A response held by the manager (ready low) consumes nothing. Its user value stays the same until the handshake completes, and the next response then shows the next stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_ar_valid | input | 1 | Manager read address valid |
| m_ar_ready | output | 1 | Manager read address ready |
| m_ar_id | input | ID_W | Manager read ID |
| m_ar_addr | input | ADDR_W | Manager read address |
| m_ar_user | input | USER_W | Manager read user sideband |
| s_ar_valid | output | 1 | Downstream read address valid |
| s_ar_ready | input | 1 | Downstream read address ready |
| s_ar_id | output | ID_W | Downstream read ID |
| s_ar_addr | output | ADDR_W | Downstream read address |
| m_aw_valid | input | 1 | Manager write address valid |
| m_aw_ready | output | 1 | Manager write address ready |
| m_aw_id | input | ID_W | Manager write ID |
| m_aw_addr | input | ADDR_W | Manager write address |
| m_aw_user | input | USER_W | Manager write user sideband |
| s_aw_valid | output | 1 | Downstream write address valid |
| s_aw_ready | input | 1 | Downstream write address ready |
| s_aw_id | output | ID_W | Downstream write ID |
| s_aw_addr | output | ADDR_W | Downstream write address |
| m_w_valid | input | 1 | Manager write data valid |
| m_w_ready | output | 1 | Manager write data ready |
| m_w_data | input | DATA_W | Manager write data |
| m_w_last | input | 1 | Manager write last beat |
| s_w_valid | output | 1 | Downstream write data valid |
| s_w_ready | input | 1 | Downstream write data ready |
| s_w_data | output | DATA_W | Downstream write data |
| s_w_last | output | 1 | Downstream write last beat |
| s_b_valid | input | 1 | Downstream write response valid |
| s_b_ready | output | 1 | Downstream write response ready |
| s_b_id | input | ID_W | Downstream write response ID |
| s_b_resp | input | 2 | Downstream write response code |
| m_b_valid | output | 1 | Manager write response valid |
| m_b_ready | input | 1 | Manager write response ready |
| m_b_id | output | ID_W | Manager write response ID |
| m_b_resp | output | 2 | Manager write response code |
| m_b_user | output | USER_W | Restored write user value |
| s_r_valid | input | 1 | Downstream read data valid |
| s_r_ready | output | 1 | Downstream read data ready |
| s_r_id | input | ID_W | Downstream read ID |
| s_r_data | input | DATA_W | Downstream read data |
| s_r_resp | input | 2 | Downstream read response code |
| s_r_last | input | 1 | Downstream read last beat |
| m_r_valid | output | 1 | Manager read data valid |
| m_r_ready | input | 1 | Manager read data ready |
| m_r_id | output | ID_W | Manager read ID |
| m_r_data | output | DATA_W | Manager read data |
| m_r_resp | output | 2 | Manager read response code |
| m_r_last | output | 1 | Manager read last beat |
| m_r_user | output | USER_W | Restored read user value |

## Verification
A queue pointer or count that goes wrong shows up on the first response for the affected ID, which carries a user value from the wrong request. It also shows up as a request that is stalled when it should pass, or passes when it should stall, at the next address for that ID. A read queue that is consumed on every beat instead of on the last one shows up on the second beat of a burst. A full-flag error shows up in the same cycle as the request that exceeds the cap, seen as ready and downstream valid. The bench therefore compares the user value on every response beat, and both ready signals at each request, with values it works out from its own record of what was sent.

// File: rtl/usr_strip_pkg.sv
package usr_strip_pkg;
  // Effective per-ID queue depth: a zero cap selects the built-in maximum.
  function automatic int depth_of(input int cap, input int max_depth);
    return (cap == 0) ? max_depth : cap;
  endfunction
endpackage

// File: rtl/usr_rst_sync.sv
module usr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/usr_id_fifo.sv
module usr_id_fifo #(
  parameter int USER_W = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [USER_W-1:0] push_data,
  input  logic              pop,
  output logic [USER_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [USER_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage needs no reset: the count gates every read of it.
  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_data;
  end

  assign head  = slot_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/usr_id_table.sv
module usr_id_table #(
  parameter int ID_W   = 2,
  parameter int USER_W = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_push,
  input  logic [USER_W-1:0] req_user,
  output logic              req_full,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic              rsp_pop,
  output logic [USER_W-1:0] rsp_user,
  output logic              rsp_empty
);
  localparam int NID = 1 << ID_W;

  logic [NID-1:0]    full_v, empty_v;
  logic [USER_W-1:0] head_a [NID];

  for (genvar g = 0; g < NID; g++) begin : g_id
    usr_id_fifo #(.USER_W(USER_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (req_push && (req_id == ID_W'(g))),
      .push_data (req_user),
      .pop       (rsp_pop && (rsp_id == ID_W'(g))),
      .head      (head_a[g]),
      .full      (full_v[g]),
      .empty     (empty_v[g])
    );
  end

  assign req_full  = full_v[req_id];
  assign rsp_user  = head_a[rsp_id];
  assign rsp_empty = empty_v[rsp_id];
endmodule

// File: rtl/usr_strip_top.sv
module usr_strip_top
  import usr_strip_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int USER_W     = 4,
  parameter int MAX_FLIGHT = 0,
  parameter int MAX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_ar_valid,
  output logic              m_ar_ready,
  input  logic [ID_W-1:0]   m_ar_id,
  input  logic [ADDR_W-1:0] m_ar_addr,
  input  logic [USER_W-1:0] m_ar_user,
  output logic              s_ar_valid,
  input  logic              s_ar_ready,
  output logic [ID_W-1:0]   s_ar_id,
  output logic [ADDR_W-1:0] s_ar_addr,
  input  logic              m_aw_valid,
  output logic              m_aw_ready,
  input  logic [ID_W-1:0]   m_aw_id,
  input  logic [ADDR_W-1:0] m_aw_addr,
  input  logic [USER_W-1:0] m_aw_user,
  output logic              s_aw_valid,
  input  logic              s_aw_ready,
  output logic [ID_W-1:0]   s_aw_id,
  output logic [ADDR_W-1:0] s_aw_addr,
  input  logic              m_w_valid,
  output logic              m_w_ready,
  input  logic [DATA_W-1:0] m_w_data,
  input  logic              m_w_last,
  output logic              s_w_valid,
  input  logic              s_w_ready,
  output logic [DATA_W-1:0] s_w_data,
  output logic              s_w_last,
  input  logic              s_b_valid,
  output logic              s_b_ready,
  input  logic [ID_W-1:0]   s_b_id,
  input  logic [1:0]        s_b_resp,
  output logic              m_b_valid,
  input  logic              m_b_ready,
  output logic [ID_W-1:0]   m_b_id,
  output logic [1:0]        m_b_resp,
  output logic [USER_W-1:0] m_b_user,
  input  logic              s_r_valid,
  output logic              s_r_ready,
  input  logic [ID_W-1:0]   s_r_id,
  input  logic [DATA_W-1:0] s_r_data,
  input  logic [1:0]        s_r_resp,
  input  logic              s_r_last,
  output logic              m_r_valid,
  input  logic              m_r_ready,
  output logic [ID_W-1:0]   m_r_id,
  output logic [DATA_W-1:0] m_r_data,
  output logic [1:0]        m_r_resp,
  output logic              m_r_last,
  output logic [USER_W-1:0] m_r_user
);
  localparam int DEPTH = depth_of(MAX_FLIGHT, MAX_DEPTH);

  logic rst_n_int;
  logic rd_full, rd_empty, wr_full, wr_empty;
  logic ar_fire, r_done, aw_fire, b_done;

  usr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  // Read address: stall only the ID whose queue is full.
  assign s_ar_valid = m_ar_valid & ~rd_full;
  assign m_ar_ready = s_ar_ready & ~rd_full;
  assign s_ar_id    = m_ar_id;
  assign s_ar_addr  = m_ar_addr;
  assign ar_fire    = m_ar_valid & m_ar_ready;

  // Write address.
  assign s_aw_valid = m_aw_valid & ~wr_full;
  assign m_aw_ready = s_aw_ready & ~wr_full;
  assign s_aw_id    = m_aw_id;
  assign s_aw_addr  = m_aw_addr;
  assign aw_fire    = m_aw_valid & m_aw_ready;

  // Write data is untouched.
  assign s_w_valid = m_w_valid;
  assign m_w_ready = s_w_ready;
  assign s_w_data  = m_w_data;
  assign s_w_last  = m_w_last;

  // Read data: every beat shows the head value, the last beat consumes it.
  assign m_r_valid = s_r_valid;
  assign s_r_ready = m_r_ready;
  assign m_r_id    = s_r_id;
  assign m_r_data  = s_r_data;
  assign m_r_resp  = s_r_resp;
  assign m_r_last  = s_r_last;
  assign r_done    = s_r_valid & s_r_ready & s_r_last;

  // Write response: consumed on the handshake.
  assign m_b_valid = s_b_valid;
  assign s_b_ready = m_b_ready;
  assign m_b_id    = s_b_id;
  assign m_b_resp  = s_b_resp;
  assign b_done    = s_b_valid & s_b_ready;

  usr_id_table #(.ID_W(ID_W), .USER_W(USER_W), .DEPTH(DEPTH)) u_rd_tab (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_id    (m_ar_id),
    .req_push  (ar_fire),
    .req_user  (m_ar_user),
    .req_full  (rd_full),
    .rsp_id    (s_r_id),
    .rsp_pop   (r_done),
    .rsp_user  (m_r_user),
    .rsp_empty (rd_empty)
  );

  usr_id_table #(.ID_W(ID_W), .USER_W(USER_W), .DEPTH(DEPTH)) u_wr_tab (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_id    (m_aw_id),
    .req_push  (aw_fire),
    .req_user  (m_aw_user),
    .req_full  (wr_full),
    .rsp_id    (s_b_id),
    .rsp_pop   (b_done),
    .rsp_user  (m_b_user),
    .rsp_empty (wr_empty)
  );
endmodule

// File: rtl/usr_strip_chk.sv
module usr_strip_chk #(
  parameter int ID_W   = 2,
  parameter int USER_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_ar_valid,
  input logic              m_ar_ready,
  input logic [ID_W-1:0]   m_ar_id,
  input logic              s_ar_valid,
  input logic              s_ar_ready,
  input logic [ID_W-1:0]   s_ar_id,
  input logic              m_aw_valid,
  input logic              m_aw_ready,
  input logic              s_aw_valid,
  input logic              rd_full,
  input logic              rd_empty,
  input logic              wr_full,
  input logic              wr_empty,
  input logic              s_r_valid,
  input logic [ID_W-1:0]   s_r_id,
  input logic              s_b_valid,
  input logic              m_r_valid,
  input logic              m_r_ready,
  input logic [USER_W-1:0] m_r_user
);
  // R1: an upstream handshake is always a downstream handshake with the same ID
  a_r1_ar_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ar_valid && m_ar_ready) |-> (s_ar_valid && s_ar_ready && s_ar_id == m_ar_id));

  // R6: a full read queue holds its request off on both sides
  a_r6_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ar_valid && rd_full) |-> (!m_ar_ready && !s_ar_valid));

  // R6: same for the write side
  a_r6_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_aw_valid && wr_full) |-> (!m_aw_ready && !s_aw_valid));

  // R3: a read beat only arrives for an ID that has an outstanding request
  a_r3_r_owner: assert property (@(posedge clk) disable iff (!rst_n)
    s_r_valid |-> !rd_empty);

  // R4: a write response only arrives for an ID that has an outstanding request
  a_r4_b_owner: assert property (@(posedge clk) disable iff (!rst_n)
    s_b_valid |-> !wr_empty);

  // R10: a held read beat keeps its user value
  a_r10_user_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_r_valid && !m_r_ready) |=> (!(s_r_valid && $stable(s_r_id)) || $stable(m_r_user)));
endmodule

bind usr_strip_top usr_strip_chk #(.ID_W(ID_W), .USER_W(USER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m_ar_valid (m_ar_valid),
  .m_ar_ready (m_ar_ready),
  .m_ar_id    (m_ar_id),
  .s_ar_valid (s_ar_valid),
  .s_ar_ready (s_ar_ready),
  .s_ar_id    (s_ar_id),
  .m_aw_valid (m_aw_valid),
  .m_aw_ready (m_aw_ready),
  .s_aw_valid (s_aw_valid),
  .rd_full    (rd_full),
  .rd_empty   (rd_empty),
  .wr_full    (wr_full),
  .wr_empty   (wr_empty),
  .s_r_valid  (s_r_valid),
  .s_r_id     (s_r_id),
  .s_b_valid  (s_b_valid),
  .m_r_valid  (m_r_valid),
  .m_r_ready  (m_r_ready),
  .m_r_user   (m_r_user)
);

// File: tb/usr_strip_top_tb.sv
`timescale 1ns/1ps
module usr_strip_top_tb;
  localparam int ID_W = 2, ADDR_W = 16, DATA_W = 32, USER_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic m_ar_valid, m_ar_ready, s_ar_valid, s_ar_ready;
  logic [ID_W-1:0] m_ar_id, s_ar_id;
  logic [ADDR_W-1:0] m_ar_addr, s_ar_addr;
  logic [USER_W-1:0] m_ar_user;
  logic m_aw_valid, m_aw_ready, s_aw_valid, s_aw_ready;
  logic [ID_W-1:0] m_aw_id, s_aw_id;
  logic [ADDR_W-1:0] m_aw_addr, s_aw_addr;
  logic [USER_W-1:0] m_aw_user;
  logic m_w_valid, m_w_ready, m_w_last, s_w_valid, s_w_ready, s_w_last;
  logic [DATA_W-1:0] m_w_data, s_w_data;
  logic s_b_valid, s_b_ready, m_b_valid, m_b_ready;
  logic [ID_W-1:0] s_b_id, m_b_id;
  logic [1:0] s_b_resp, m_b_resp;
  logic [USER_W-1:0] m_b_user;
  logic s_r_valid, s_r_ready, s_r_last, m_r_valid, m_r_ready, m_r_last;
  logic [ID_W-1:0] s_r_id, m_r_id;
  logic [DATA_W-1:0] s_r_data, m_r_data;
  logic [1:0] s_r_resp, m_r_resp;
  logic [USER_W-1:0] m_r_user;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usr_strip_top u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Read address; exp_ok says whether the request should pass this cycle.
  task automatic do_ar(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                       input logic [USER_W-1:0] u, input bit exp_ok, input string tag);
    m_ar_valid = 1'b1; m_ar_id = id; m_ar_addr = a; m_ar_user = u; s_ar_ready = 1'b1;
    #1;
    chk(m_ar_ready == exp_ok && s_ar_valid == exp_ok, tag, {m_ar_ready, s_ar_valid}, {exp_ok, exp_ok});
    if (exp_ok) chk(s_ar_id == id && s_ar_addr == a, "R1 ar fields", {s_ar_id, s_ar_addr}, {id, a});
    @(posedge clk); @(negedge clk);
    m_ar_valid = 1'b0;
  endtask

  task automatic do_aw(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                       input logic [USER_W-1:0] u);
    m_aw_valid = 1'b1; m_aw_id = id; m_aw_addr = a; m_aw_user = u; s_aw_ready = 1'b1;
    #1;
    chk(m_aw_ready && s_aw_valid && s_aw_id == id && s_aw_addr == a, "R2 aw forward",
        {m_aw_ready, s_aw_valid, s_aw_id, s_aw_addr}, {2'b11, id, a});
    @(posedge clk); @(negedge clk);
    m_aw_valid = 1'b0;
  endtask

  task automatic do_r(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d, input bit last,
                      input logic [USER_W-1:0] exp_u, input string tag);
    s_r_valid = 1'b1; s_r_id = id; s_r_data = d; s_r_last = last; s_r_resp = 2'b00; m_r_ready = 1'b1;
    #1;
    chk(m_r_valid && m_r_id == id && m_r_data == d && m_r_last == last, "R3 r fields",
        {m_r_valid, m_r_id, m_r_last}, {1'b1, id, last});
    chk(m_r_user == exp_u, tag, m_r_user, exp_u);
    @(posedge clk); @(negedge clk);
    s_r_valid = 1'b0;
  endtask

  task automatic do_b(input logic [ID_W-1:0] id, input logic [USER_W-1:0] exp_u, input string tag);
    s_b_valid = 1'b1; s_b_id = id; s_b_resp = 2'b10; m_b_ready = 1'b1;
    #1;
    chk(m_b_valid && m_b_id == id && m_b_resp == 2'b10, "R4 b fields",
        {m_b_valid, m_b_id, m_b_resp}, {1'b1, id, 2'b10});
    chk(m_b_user == exp_u, tag, m_b_user, exp_u);
    @(posedge clk); @(negedge clk);
    s_b_valid = 1'b0;
  endtask

  task automatic t_reset();
    s_ar_ready = 1'b1; s_aw_ready = 1'b1;
    #1;
    chk(m_ar_ready && m_aw_ready, "R9 ready after reset", {m_ar_ready, m_aw_ready}, 2'b11);
    chk(!m_r_valid && !m_b_valid, "R9 no response after reset", {m_r_valid, m_b_valid}, 2'b00);
    s_ar_ready = 1'b0; s_aw_ready = 1'b0;
    #1;
    chk(!m_ar_ready && !m_aw_ready, "R9 ready follows downstream", {m_ar_ready, m_aw_ready}, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_read_burst();
    do_ar(2'd1, 16'h1000, 4'h5, 1'b1, "R1 ar accept");
    do_ar(2'd1, 16'h1040, 4'h6, 1'b1, "R1 ar accept");
    do_r(2'd1, 32'hA0, 1'b0, 4'h5, "R3 beat0 user");
    do_r(2'd1, 32'hA1, 1'b0, 4'h5, "R3 beat1 user");
    do_r(2'd1, 32'hA2, 1'b1, 4'h5, "R3 last beat user");
    do_r(2'd1, 32'hB0, 1'b1, 4'h6, "R5 second request user");
  endtask

  task automatic t_write();
    do_aw(2'd2, 16'h2000, 4'h3);
    do_aw(2'd2, 16'h2010, 4'h7);
    m_w_valid = 1'b1; m_w_data = 32'hDEAD_BEEF; m_w_last = 1'b1; s_w_ready = 1'b0;
    #1;
    chk(s_w_valid && s_w_data == 32'hDEAD_BEEF && s_w_last && !m_w_ready, "R8 w pass",
        {s_w_valid, s_w_last, m_w_ready}, 3'b110);
    s_w_ready = 1'b1;
    #1;
    chk(m_w_ready, "R8 w ready pass", m_w_ready, 1);
    m_w_valid = 1'b0;
    @(negedge clk);
    do_b(2'd2, 4'h3, "R4 first write user");
    do_b(2'd2, 4'h7, "R5 second write user");
  endtask

  task automatic t_hold();
    do_ar(2'd2, 16'h3000, 4'hA, 1'b1, "R1 ar accept");
    do_ar(2'd2, 16'h3004, 4'hB, 1'b1, "R1 ar accept");
    s_r_valid = 1'b1; s_r_id = 2'd2; s_r_data = 32'h55; s_r_last = 1'b1; m_r_ready = 1'b0;
    for (int i = 0; i < 2; i++) begin
      #1;
      chk(m_r_user == 4'hA && !s_r_ready, "R10 held beat", {s_r_ready, m_r_user}, {1'b0, 4'hA});
      @(negedge clk);
    end
    s_r_valid = 1'b0;
    do_r(2'd2, 32'h55, 1'b1, 4'hA, "R10 released beat");
    do_r(2'd2, 32'h56, 1'b1, 4'hB, "R10 next value");
  endtask

  task automatic t_cap();
    for (int i = 0; i < 4; i++) do_ar(2'd0, 16'h4000, 4'(i + 1), 1'b1, "R6 below cap");
    do_ar(2'd0, 16'h4100, 4'hE, 1'b0, "R6 full id stalled");
    do_ar(2'd3, 16'h5000, 4'hC, 1'b1, "R6 other id passes");
    do_r(2'd0, 32'h1, 1'b1, 4'h1, "R5 order 1");
    do_ar(2'd0, 16'h4200, 4'h9, 1'b1, "R6 accept after drain");
    do_r(2'd0, 32'h2, 1'b1, 4'h2, "R5 order 2");
    do_r(2'd0, 32'h3, 1'b1, 4'h3, "R5 order 3");
    do_r(2'd0, 32'h4, 1'b1, 4'h4, "R5 order 4");
    do_r(2'd0, 32'h5, 1'b1, 4'h9, "R5 order 5");
    do_r(2'd3, 32'h6, 1'b1, 4'hC, "R6 other id user");
  endtask

  task automatic t_sep();
    do_ar(2'd1, 16'h6000, 4'h2, 1'b1, "R7 read accept");
    do_aw(2'd1, 16'h6000, 4'hD);
    do_b(2'd1, 4'hD, "R7 write user separate");
    do_r(2'd1, 32'h77, 1'b1, 4'h2, "R7 read user separate");
  endtask

  initial begin
    rst_n = 1'b0;
    {m_ar_valid, s_ar_ready, m_aw_valid, s_aw_ready, m_w_valid, s_w_ready} = '0;
    {s_b_valid, m_b_ready, s_r_valid, m_r_ready, m_w_last, s_r_last} = '0;
    m_ar_id = '0; m_ar_addr = '0; m_ar_user = '0;
    m_aw_id = '0; m_aw_addr = '0; m_aw_user = '0;
    m_w_data = '0; s_b_id = '0; s_b_resp = '0;
    s_r_id = '0; s_r_data = '0; s_r_resp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_burst();
    t_write();
    t_hold();
    t_cap();
    t_sep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule